// File: doc/BRIEF.md
# Tamper Event Response Router

The router takes a set of security event lines and sends each one to any number of response targets. Target 0 is the interrupt. The other targets drive one response output each. Two extra events can be raised by software. For every event there is a sticky status bit. An event's status bit reaches a target only when the (target, event) pair is in the routed state.

Each pair is configured through two redundant 2-bit fields, a primary code and a secondary code, which sit in separate select words. Only two combinations can be written. One is "off, open", which is the reset value. The other is "on, open". Any other combination counts as routed and freezes both fields until the next core reset. A corrupted or deliberately locked code therefore always fails towards a response and never towards silence.

A target's status bit is set while a routed event is pending. It drives the target's output and stays set until software clears it after the cause has gone. All registers use one synchronous write port and a combinational read port addressed in words.

Top module: `tamper_router`

## Requirements
- R1: After reset every primary and secondary code is 2'b10, all status bits are 0, and irq_o and resp_o are low.
- R2: For target t and event e, the primary code is at bits [2*(e%16)+1 : 2*(e%16)] of the word at address 64 + 2*(t*NGRP + e/16). The secondary code is at the same bits of the next address. A read returns the stored codes. Bit positions with no event read 0 and ignore writes.
- R3: A pair with primary 10 and secondary 10 is not routed. A pair with primary 01 and secondary 10 is routed. Any other combination is routed and locked.
- R4: While a pair is locked, writes to either of its fields are dropped. Only reset reopens the pair.
- R5: A rising edge on ev_i[e] sets status bit e. The bit is at word e/16, bit e%16. It stays set after the input falls. Writing 1 to the bit clears it. A new set in the same cycle as a clear wins.
- R6: A nonzero write to address 8 sets the status of event NUM_HW. A nonzero write to address 9 sets the status of event NUM_HW+1. A zero write to either address does nothing.
- R7: The status of target t is at word 0, bit 16+t. It sets one cycle after any routed event of t has its status set. irq_o shows target 0 and resp_o[t-1] shows target t.
- R8: Writing 1 to a target's status bit clears it only if none of that target's routed events is still pending.
- R9: An event whose status is set but which is routed to no target leaves every target status and output unchanged.
- R10: Status bits with no event or target behind them read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Core reset, active low, asynchronous |
| ev_i | input | NUM_HW | Synchronised hardware event levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | 32 | Read data, combinational |
| irq_o | output | 1 | Interrupt target output |
| resp_o | output | NUM_RESP | Response target outputs |

## Verification
A corrupted select code shows in two places: as a changed value when the word is read back, and as a target that fires on an event it should ignore, or stays quiet on one it should act on, two cycles after the event edge. A lock that fails to hold shows on the first read after an overwrite attempt. A status bit that leaks or fails to stick shows on the next status read, or as an output that drops while its cause is still pending. A clear that goes through too early drops the output one cycle after the write, even though the pending event is still there.

// File: rtl/trr_pkg.sv
package trr_pkg;
  localparam logic [1:0] CODE_IDLE = 2'b10;
  localparam logic [1:0] CODE_ON   = 2'b01;

  // pair may still be written: primary in {01,10} and secondary exactly 10
  function automatic logic pair_open(input logic [1:0] pri, input logic [1:0] sec);
    return ((pri == CODE_ON) || (pri == CODE_IDLE)) && (sec == CODE_IDLE);
  endfunction

  // every combination except the idle default routes the event
  function automatic logic pair_routed(input logic [1:0] pri, input logic [1:0] sec);
    return !((pri == CODE_IDLE) && (sec == CODE_IDLE));
  endfunction

  // word address of a select word
  function automatic int sel_word_addr(input int tgt, input int grp, input int half,
                                       input int ngrp, input int base);
    return base + 2 * (tgt * ngrp + grp) + half;
  endfunction
endpackage

// File: rtl/trr_pair_cell.sv
module trr_pair_cell
  import trr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_pri,
  input  logic       wr_sec,
  input  logic [1:0] wd_pri,
  input  logic [1:0] wd_sec,
  output logic [1:0] pri_q,
  output logic [1:0] sec_q,
  output logic       routed
);
  logic open_now;
  assign open_now = pair_open(pri_q, sec_q);
  assign routed   = pair_routed(pri_q, sec_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= CODE_IDLE;
      sec_q <= CODE_IDLE;
    end else if (open_now) begin
      if (wr_pri) pri_q <= wd_pri;
      if (wr_sec) sec_q <= wd_sec;
    end
  end

  // R4: a closed pair never changes and never reopens
  assert_lock_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !open_now |=> ($stable(pri_q) && $stable(sec_q)));
  // R3: a closed pair always routes
  assert_locked_routes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pri || wr_sec) && !open_now |=> routed);
endmodule

// File: rtl/trr_event_status.sv
module trr_event_status #(
  parameter int NEV = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] lvl_i,
  input  logic [NEV-1:0] pulse_i,
  input  logic [NEV-1:0] clr_i,
  output logic [NEV-1:0] stat_q
);
  logic [NEV-1:0] lvl_q;
  logic [NEV-1:0] rise;
  assign rise = (lvl_i & ~lvl_q) | pulse_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      stat_q <= '0;
    end else begin
      lvl_q  <= lvl_i;
      stat_q <= (stat_q & ~clr_i) | rise;
    end
  end

  // R5: a rising edge always lands in status
  assert_edge_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(rise) & ~stat_q) == '0));
  // R5: set bits survive unless written with 1
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_q) & ~$past(clr_i) & ~stat_q) == '0));
endmodule

// File: rtl/trr_action_status.sv
module trr_action_status #(
  parameter int NT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] cause_i,
  input  logic [NT-1:0] clr_i,
  output logic [NT-1:0] stat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_i) | cause_i;
  end

  // R7: a pending routed cause sets the target on the next edge
  assert_cause_latches_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(cause_i) & ~stat_q) == '0));
  // R8: a target holds until cleared with its cause gone
  assert_target_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_q) & ~$past(clr_i) & ~stat_q) == '0));
  // R9: a target never rises without a cause
  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(cause_i)) == '0));
endmodule

// File: rtl/tamper_router.sv
module tamper_router
  import trr_pkg::*;
#(
  parameter int NUM_HW   = 18,
  parameter int NUM_RESP = 2,
  parameter int ADDR_W   = 8,
  parameter int SEL_BASE = 64,
  parameter int SW0_ADDR = 8,
  parameter int SW1_ADDR = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_HW-1:0]   ev_i,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [31:0]         wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [31:0]         rd_data,
  output logic                irq_o,
  output logic [NUM_RESP-1:0] resp_o
);
  localparam int NEV    = NUM_HW + 2;
  localparam int NT     = NUM_RESP + 1;
  localparam int GRP_SZ = 16;
  localparam int NGRP   = (NEV + GRP_SZ - 1) / GRP_SZ;
  localparam int NPAD   = NGRP * GRP_SZ;

  logic [NEV-1:0]                  ev_stat, ev_clr, ev_pulse, ev_lvl;
  logic [NPAD-1:0]                 ev_pad;
  logic [NT-1:0]                   act_stat, act_clr, cause;
  logic [NT-1:0][NEV-1:0]          route_m;
  logic [NT-1:0][NGRP-1:0][1:0][31:0] selw;
  logic                            sw0_hit, sw1_hit;

  assign sw0_hit  = wr_en && (wr_addr == ADDR_W'(SW0_ADDR)) && (wr_data != '0);
  assign sw1_hit  = wr_en && (wr_addr == ADDR_W'(SW1_ADDR)) && (wr_data != '0);
  assign ev_lvl   = NEV'(ev_i);
  assign ev_pulse = {sw1_hit, sw0_hit, {NUM_HW{1'b0}}};
  assign ev_pad   = NPAD'(ev_stat);

  for (genvar e = 0; e < NEV; e++) begin : g_evclr
    assign ev_clr[e] = wr_en && (wr_addr == ADDR_W'(e / GRP_SZ)) && wr_data[e % GRP_SZ];
  end

  for (genvar t = 0; t < NT; t++) begin : g_tgt
    assign act_clr[t] = wr_en && (wr_addr == '0) && wr_data[GRP_SZ + t];
    assign cause[t]   = |(route_m[t] & ev_stat);
    for (genvar e = 0; e < NPAD; e++) begin : g_ev
      localparam int G = e / GRP_SZ;
      localparam int K = e % GRP_SZ;
      if (e < NEV) begin : g_cell
        localparam int A0 = sel_word_addr(t, G, 0, NGRP, SEL_BASE);
        logic [1:0] pri, sec;
        trr_pair_cell u_pair (
          .clk    (clk),
          .rst_n  (rst_n),
          .wr_pri (wr_en && (wr_addr == ADDR_W'(A0))),
          .wr_sec (wr_en && (wr_addr == ADDR_W'(A0 + 1))),
          .wd_pri (wr_data[2*K +: 2]),
          .wd_sec (wr_data[2*K +: 2]),
          .pri_q  (pri),
          .sec_q  (sec),
          .routed (route_m[t][e])
        );
        assign selw[t][G][0][2*K +: 2] = pri;
        assign selw[t][G][1][2*K +: 2] = sec;
      end else begin : g_pad
        assign selw[t][G][0][2*K +: 2] = 2'b00;
        assign selw[t][G][1][2*K +: 2] = 2'b00;
      end
    end
  end

  trr_event_status #(.NEV(NEV)) u_evs (
    .clk(clk), .rst_n(rst_n), .lvl_i(ev_lvl), .pulse_i(ev_pulse),
    .clr_i(ev_clr), .stat_q(ev_stat)
  );

  trr_action_status #(.NT(NT)) u_act (
    .clk(clk), .rst_n(rst_n), .cause_i(cause), .clr_i(act_clr), .stat_q(act_stat)
  );

  assign irq_o  = act_stat[0];
  assign resp_o = act_stat[NT-1:1];

  always_comb begin
    rd_data = '0;
    for (int g = 0; g < NGRP; g++)
      if (rd_addr == ADDR_W'(g)) rd_data[GRP_SZ-1:0] = ev_pad[g*GRP_SZ +: GRP_SZ];
    if (rd_addr == '0) rd_data[GRP_SZ +: NT] = act_stat;
    for (int t = 0; t < NT; t++)
      for (int g = 0; g < NGRP; g++)
        for (int h = 0; h < 2; h++)
          if (rd_addr == ADDR_W'(sel_word_addr(t, g, h, NGRP, SEL_BASE)))
            rd_data = selw[t][g][h];
  end

  // R6: a nonzero write to a software trigger raises its event
  assert_sw_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw0_hit |=> ev_stat[NUM_HW]);
  assert_sw_event1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw1_hit |=> ev_stat[NUM_HW+1]);
  // R9: with nothing routed and pending, the interrupt cannot rise
  assert_irq_needs_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cause[0] && !irq_o |=> !irq_o);
endmodule

// File: tb/tamper_router_test.sv
module tamper_router_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_HW = 18;
  localparam int NUM_RESP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_HW-1:0] ev_i = '0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic irq_o;
  logic [NUM_RESP-1:0] resp_o;

  int n_chk = 0;
  int n_fail = 0;
  bit mon_go = 1'b0;
  bit done = 1'b0;

  typedef struct {
    bit          is_out;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tamper_router uut (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_o(irq_o), .resp_o(resp_o)
  );

  // expected select word: base code everywhere, one field replaced
  function automatic logic [31:0] fld(input logic [31:0] base, input int idx, input logic [1:0] code);
    logic [31:0] w;
    w = base;
    w[2*idx +: 2] = code;
    return w;
  endfunction

  // monitor: pops one expectation per request and compares
  always @(negedge clk) begin
    if (mon_go && sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      act = it.is_out ? 32'({resp_o, irq_o}) : rd_data;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    rd_addr = a;
    sbq.push_back('{1'b0, e, tag});
    mon_go = 1'b1;
    @(negedge clk); #1;
    mon_go = 1'b0;
  endtask

  task automatic expect_out(input logic [2:0] e, input string tag);
    @(posedge clk); #1;
    sbq.push_back('{1'b1, 32'(e), tag});
    mon_go = 1'b1;
    @(negedge clk); #1;
    mon_go = 1'b0;
  endtask

  task automatic pulse(input int idx);
    @(posedge clk); #1; ev_i[idx] = 1'b1;
    @(posedge clk); #1; ev_i[idx] = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] idle_w;
    idle_w = 32'hAAAA_AAAA;
    do_reset();
    // R1 reset state
    expect_rd(8'h40, idle_w, "R1 irq sel group0");
    expect_rd(8'h42, 32'h0000_00AA, "R1 R2 R10 irq sel group1 only 4 fields");
    expect_rd(8'h00, 32'h0, "R1 status0");
    expect_rd(8'h01, 32'h0, "R1 status1");
    expect_out(3'b000, "R1 outputs");
    // R2 R3 route event 3 to interrupt
    wr(8'h40, fld(idle_w, 3, 2'b01));
    expect_rd(8'h40, 32'hAAAA_AA6A, "R2 field of event 3");
    pulse(3);
    expect_rd(8'h00, 32'h0001_0008, "R5 R7 event3 and irq status");
    expect_out(3'b001, "R7 irq raised");
    // R8 clear ignored while cause pending
    wr(8'h00, 32'h0001_0000);
    expect_rd(8'h00, 32'h0001_0008, "R8 target clear ignored, R5 sticky");
    wr(8'h00, 32'h0000_0008);
    expect_rd(8'h00, 32'h0001_0000, "R5 event clear");
    expect_out(3'b001, "R8 irq held");
    wr(8'h00, 32'h0001_0000);
    expect_rd(8'h00, 32'h0, "R8 target cleared");
    expect_out(3'b000, "R8 irq dropped");
    // R9 unrouted event
    pulse(5);
    expect_rd(8'h00, 32'h0000_0020, "R9 event5 status only");
    expect_out(3'b000, "R9 no output");
    wr(8'h00, 32'h0000_0020);
    // R6 software events, event 18 routed to resp_o[0]
    wr(8'h46, fld(32'h0000_00AA, 2, 2'b01));
    wr(8'h08, 32'h0);
    expect_rd(8'h01, 32'h0, "R6 zero write ignored");
    wr(8'h08, 32'h5AA5_5AA5);
    expect_rd(8'h01, 32'h0000_0004, "R6 sw0 event");
    expect_out(3'b010, "R6 R7 resp0");
    wr(8'h09, 32'h0000_0001);
    expect_rd(8'h01, 32'h0000_000C, "R6 sw1 event");
    // R3 R4 lock event 7 on target 2 via secondary 11
    wr(8'h49, fld(idle_w, 7, 2'b11));
    wr(8'h49, idle_w);
    expect_rd(8'h49, 32'hAAAA_EAAA, "R4 secondary frozen");
    wr(8'h48, fld(idle_w, 7, 2'b01));
    expect_rd(8'h48, idle_w, "R4 primary frozen");
    pulse(7);
    expect_rd(8'h00, 32'h0006_0080, "R3 locked pair routes");
    expect_out(3'b110, "R3 resp1 raised");
    // R3 R4 primary 00 locks
    wr(8'h44, fld(idle_w, 0, 2'b00));
    expect_rd(8'h44, 32'hAAAA_AAA8, "R3 primary 00 stored");
    wr(8'h44, idle_w);
    expect_rd(8'h44, 32'hAAAA_AAA8, "R4 primary 00 frozen");
    // R10 R2 upper group: missing fields stay 0
    wr(8'h42, 32'h5555_5555);
    expect_rd(8'h42, 32'h0000_0055, "R10 R2 absent fields read 0");
    expect_out(3'b111, "R7 irq from pending sw events");
    wr(8'h01, 32'hFFFF_FFF0);
    expect_rd(8'h01, 32'h0000_000C, "R10 reserved status writes ignored");
    // R4 reset reopens
    do_reset();
    expect_rd(8'h49, idle_w, "R4 reset reopens");
    expect_rd(8'h00, 32'h0, "R1 status after reset");
    expect_out(3'b000, "R1 outputs after reset");
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule